// File: doc/BRIEF.md
# Double-Buffered Frame-Synchronised Serial Transmitter

This block is the transmit half of a synchronous serial port. A host places a word in a holding register through a one-cycle write strobe. When a frame pulse arrives, the block moves the pending word into a separate shifter and sends it most-significant bit first, one bit per clock, with an enable output that marks the data bits. The first bit can follow the frame pulse by zero, one or two clocks, as set by a delay input.

A ready output tells the host when the holding register may be refilled. Ready rises when the pending word moves into the shifter and falls when the host writes. If the host writes twice before that move, only the second word is sent. If a frame pulse finds no fresh word, the shifter sends its previous word again and a sticky underflow flag is raised. A frame pulse that arrives sooner than one word length after the previously accepted pulse is dropped and raises a sticky early-pulse flag. The host port and the serial side share one clock. The word width `W` must be at least 3.

Top module: `ser_tx_db`

## Requirements
- R1: After reset, ready_o is 1, tx_o and tx_en_o are 0, underflow_o and early_fs_o are 0, and the shifter holds zero.
- R2: A write (wr_en_i high at a clock edge) stores wr_data_i in the holding register, and ready_o is 0 after that edge.
- R3: The move from the holding register to the shifter happens on the edge that launches the first data bit, and ready_o becomes 1 at that edge. If a write falls on the same edge, ready_o stays 0 and the written word waits for the next frame.
- R4: A frame is W bits sent most-significant bit first, one bit per clock, with tx_en_o high for each data bit.
- R5: If a frame pulse is accepted at edge k with delay_i = d, bit 0 is driven from edge k+d and bit i from edge k+d+i. A delay_i value of 3 acts as 2. The delay is captured when the pulse is accepted.
- R6: A second write before the move replaces the pending word, and the earlier word never appears on tx_o.
- R7: A frame pulse accepted while ready_o is 1 resends the shifter's previous word and sets underflow_o, which stays set until reset.
- R8: A frame pulse at an edge less than W edges after the previously accepted pulse is ignored and sets early_fs_o, which stays set until reset.
- R9: A frame pulse exactly W edges after the previously accepted pulse is accepted, and its bits follow the previous frame's last bit with no gap.
- R10: Outside data bits, tx_o and tx_en_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, also used by the host port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| delay_i | input | 2 | Delay in clocks from frame pulse to first bit (0..2, 3 acts as 2) |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | W | Host write word |
| fsync_i | input | 1 | Frame pulse, one clock wide |
| ready_o | output | 1 | Holding register free for a new word |
| tx_o | output | 1 | Serial data |
| tx_en_o | output | 1 | High while a data bit is on tx_o |
| underflow_o | output | 1 | Sticky: a frame was sent with no fresh word |
| early_fs_o | output | 1 | Sticky: a frame pulse came too soon and was dropped |

## Verification
The hardest case to reach is the back-to-back boundary at two-clock delay. There, the next frame pulse comes exactly one word length after the last accepted pulse, while two bits of the earlier frame are still in flight, and the host refills the holding register between the two moves. The bench drives that pattern from a loop indexed by clock edge, setting each input for a chosen edge and storing tx_o and tx_en_o per edge. It then checks the 2W-bit stream for an unbroken enable and the two words in order. The same edge-indexed method places a pulse one edge before the allowed point, to show that it does not restart the frame.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    DLY_0 = 2'd0,
    DLY_1 = 2'd1,
    DLY_2 = 2'd2
  } dly_e;

  // code 3 saturates to the longest supported delay
  function automatic dly_e clamp_dly(input logic [1:0] d);
    return (d == 2'd3) ? DLY_2 : dly_e'(d);
  endfunction
endpackage

// File: rtl/ser_tx_frame_timer.sv
module ser_tx_frame_timer
  import ser_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsync_i,
  input  logic [1:0] delay_i,
  output logic       start_o,
  output logic       early_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(W);

  logic [CW-1:0] gap_q;
  logic [1:0]    pipe_q;
  dly_e          dly_q;
  logic          early_q;
  logic          accept;

  // gap saturates at W: a pulse is legal once a full word time has passed
  assign accept = fsync_i && (gap_q == GAP_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= GAP_MAX;
      pipe_q  <= '0;
      dly_q   <= DLY_0;
      early_q <= 1'b0;
    end else begin
      if (accept)               gap_q <= CW'(1);
      else if (gap_q != GAP_MAX) gap_q <= gap_q + CW'(1);
      pipe_q <= {pipe_q[0], accept};
      if (accept) dly_q <= clamp_dly(delay_i);
      if (fsync_i && !accept) early_q <= 1'b1;
    end
  end

  assign start_o = (accept    && clamp_dly(delay_i) == DLY_0) ||
                   (pipe_q[0] && dly_q == DLY_1) ||
                   (pipe_q[1] && dly_q == DLY_2);
  assign early_o = early_q;
endmodule

// File: rtl/ser_tx_buffer.sv
module ser_tx_buffer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         copy_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] word_o,
  output logic         ready_o,
  output logic         underflow_o
);
  logic [W-1:0] hold_q;
  logic         ready_q;
  logic         unf_q;

  // no fresh word: relaunch whatever the shifter still holds
  assign word_o = ready_q ? prev_i : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      ready_q <= 1'b1;
      unf_q   <= 1'b0;
    end else begin
      if (copy_i) begin
        if (ready_q) unf_q   <= 1'b1;
        else         ready_q <= 1'b1;
      end
      if (wr_en_i) begin
        hold_q  <= wr_data_i;
        ready_q <= 1'b0;
      end
    end
  end

  assign ready_o     = ready_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] word_o,
  output logic         tx_o,
  output logic         tx_en_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;
  logic [W-1:0]  src;
  logic          shift;
  logic          tx_q;
  logic          en_q;

  assign src   = start_i ? load_i : sh_q;
  assign shift = start_i || (left_q != '0);

  // rotate rather than shift so the word is intact after W bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      tx_q   <= 1'b0;
      en_q   <= 1'b0;
    end else if (shift) begin
      sh_q   <= {src[W-2:0], src[W-1]};
      left_q <= start_i ? CW'(W - 1) : left_q - CW'(1);
      tx_q   <= src[W-1];
      en_q   <= 1'b1;
    end else begin
      tx_q <= 1'b0;
      en_q <= 1'b0;
    end
  end

  assign word_o  = sh_q;
  assign tx_o    = tx_q;
  assign tx_en_o = en_q;
endmodule

// File: rtl/ser_tx_db.sv
module ser_tx_db #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   delay_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         fsync_i,
  output logic         ready_o,
  output logic         tx_o,
  output logic         tx_en_o,
  output logic         underflow_o,
  output logic         early_fs_o
);
  logic         start;
  logic [W-1:0] sh_word;
  logic [W-1:0] launch_word;

  ser_tx_frame_timer #(.W(W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .delay_i (delay_i),
    .start_o (start),
    .early_o (early_fs_o)
  );

  ser_tx_buffer #(.W(W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .copy_i      (start),
    .prev_i      (sh_word),
    .word_o      (launch_word),
    .ready_o     (ready_o),
    .underflow_o (underflow_o)
  );

  ser_tx_shifter #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .load_i  (launch_word),
    .word_o  (sh_word),
    .tx_o    (tx_o),
    .tx_en_o (tx_en_o)
  );
endmodule

// File: rtl/ser_tx_db_chk.sv
module ser_tx_db_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic ready_o,
  input logic tx_o,
  input logic tx_en_o,
  input logic underflow_o,
  input logic early_fs_o
);
  assert_wr_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !ready_o);

  assert_ready_rise_with_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> tx_en_o);

  assert_underflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  assert_early_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_fs_o |=> early_fs_o);

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> !tx_o);
endmodule

bind ser_tx_db ser_tx_db_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .ready_o     (ready_o),
  .tx_o        (tx_o),
  .tx_en_o     (tx_en_o),
  .underflow_o (underflow_o),
  .early_fs_o  (early_fs_o)
);

// File: tb/ser_tx_db_tb.sv
module ser_tx_db_tb;
  localparam int W = 8;
  localparam int N = 2 * W + 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   delay_i = 2'd0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         fsync_i = 1'b0;
  logic         ready_o, tx_o, tx_en_o, underflow_o, early_fs_o;

  int checks = 0;
  int errors = 0;

  // {delay code, word}
  localparam logic [9:0] VEC [7] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81}, {2'd0, 8'hFF},
    {2'd1, 8'h00}, {2'd3, 8'h4B}, {2'd2, 8'h6E}
  };

  always #2 clk_i = ~clk_i;

  ser_tx_db #(.W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .delay_i(delay_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .fsync_i(fsync_i), .ready_o(ready_o), .tx_o(tx_o),
    .tx_en_o(tx_en_o), .underflow_o(underflow_o), .early_fs_o(early_fs_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // called at a negedge; pulse accepted at the next edge k
  task automatic run_frame(input logic [1:0] d, input logic [W-1:0] exp, input bit fresh, input string req);
    int de;
    logic [W-1:0] got;
    bit en_ok;
    de = (d == 2'd3) ? 2 : int'(d);
    en_ok = 1'b1;
    delay_i = d;
    fsync_i = 1'b1;
    @(negedge clk_i);
    fsync_i = 1'b0;
    for (int j = 0; j < de; j++) begin
      if (fresh) chk(ready_o == 1'b0, "R3 ready before copy", ready_o, 0);
      chk(tx_en_o == 1'b0, "R5 no bit during delay", tx_en_o, 0);
      @(negedge clk_i);
    end
    chk(ready_o == 1'b1, "R3 ready at copy", ready_o, 1);
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = tx_o;
      if (!tx_en_o) en_ok = 1'b0;
      @(negedge clk_i);
    end
    chk(got == exp, req, got, exp);
    chk(en_ok, "R4 enable over data bits", en_ok, 1);
    chk(tx_en_o == 1'b0 && tx_o == 1'b0, "R10 idle after frame", {tx_en_o, tx_o}, 0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic st [N];
    logic se [N];
    logic [W-1:0] w1, w2;
    bit run_ok;

    repeat (3) @(negedge clk_i);
    chk(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    chk({tx_o, tx_en_o} == 2'b00, "R1 R10 outputs idle", {tx_o, tx_en_o}, 0);
    chk({underflow_o, early_fs_o} == 2'b00, "R1 flags clear", {underflow_o, early_fs_o}, 0);

    // vector table: write, check ready drop, send, check word
    for (int v = 0; v < 7; v++) begin
      wr(VEC[v][7:0]);
      chk(ready_o == 1'b0, "R2 write clears ready", ready_o, 0);
      run_frame(VEC[v][9:8], VEC[v][7:0], 1'b1, "R4 R5 frame word");
    end

    // R6 overwrite
    wr(8'h11);
    wr(8'h22);
    chk(ready_o == 1'b0, "R2 ready low after writes", ready_o, 0);
    run_frame(2'd0, 8'h22, 1'b1, "R6 overwritten word sent");
    chk(underflow_o == 1'b0, "R7 no underflow yet", underflow_o, 0);

    // R7 underflow: no write, previous word resent
    run_frame(2'd1, 8'h22, 1'b0, "R7 resend previous word");
    chk(underflow_o == 1'b1, "R7 underflow set", underflow_o, 1);
    repeat (3) @(negedge clk_i);
    chk(underflow_o == 1'b1, "R7 underflow sticky", underflow_o, 1);

    // R9 back-to-back at delay 2, refill at edge 4 (after copy at edge 2)
    wr(8'hC3);
    delay_i = 2'd2;
    for (int c = 0; c <= N; c++) begin
      if (c > 0) begin
        st[c-1] = tx_o;
        se[c-1] = tx_en_o;
      end
      if (c == N) break;
      fsync_i = (c == 0 || c == W);
      wr_en_i = (c == 4);
      wr_data_i = 8'h5A;
      @(negedge clk_i);
    end
    fsync_i = 1'b0;
    wr_en_i = 1'b0;
    run_ok = 1'b1;
    for (int i = 0; i < W; i++) begin
      w1[W-1-i] = st[2+i];
      w2[W-1-i] = st[2+W+i];
    end
    for (int i = 2; i < 2 + 2 * W; i++) if (!se[i]) run_ok = 1'b0;
    chk(w1 == 8'hC3, "R9 first word", w1, 8'hC3);
    chk(w2 == 8'h5A, "R9 second word", w2, 8'h5A);
    chk(run_ok, "R9 continuous enable", run_ok, 1);
    chk(se[1] == 1'b0 && se[2 + 2 * W] == 1'b0, "R5 R10 stream bounds", {se[1], se[2+2*W]}, 0);
    chk(early_fs_o == 1'b0, "R9 boundary pulse not early", early_fs_o, 0);
    chk(ready_o == 1'b1, "R3 ready after second copy", ready_o, 1);

    // R8 early pulse one edge before allowed point, delay 1
    wr(8'h96);
    delay_i = 2'd1;
    for (int c = 0; c <= N; c++) begin
      if (c > 0) begin
        st[c-1] = tx_o;
        se[c-1] = tx_en_o;
      end
      if (c == N) break;
      fsync_i = (c == 0 || c == W - 1);
      @(negedge clk_i);
    end
    fsync_i = 1'b0;
    for (int i = 0; i < W; i++) w1[W-1-i] = st[1+i];
    chk(w1 == 8'h96, "R8 frame unaffected", w1, 8'h96);
    chk(se[W+1] == 1'b0, "R8 no restart after early pulse", se[W+1], 0);
    chk(early_fs_o == 1'b1, "R8 early flag set", early_fs_o, 1);
    repeat (2) @(negedge clk_i);
    chk(early_fs_o == 1'b1, "R8 early flag sticky", early_fs_o, 1);

    // R3 write on the copy edge keeps ready low, word waits
    wr(8'h0F);
    delay_i = 2'd0;
    fsync_i = 1'b1;
    wr_en_i = 1'b1;
    wr_data_i = 8'hE7;
    @(negedge clk_i);
    fsync_i = 1'b0;
    wr_en_i = 1'b0;
    chk(ready_o == 1'b0, "R3 same-edge write keeps ready low", ready_o, 0);
    repeat (W + 1) @(negedge clk_i);
    run_frame(2'd0, 8'hE7, 1'b1, "R3 pending word sent next");

    // R1 reset mid-frame
    wr(8'hAA);
    fsync_i = 1'b1;
    @(negedge clk_i);
    fsync_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk({ready_o, tx_en_o, underflow_o, early_fs_o} == 4'b1000, "R1 reset clears state",
        {ready_o, tx_en_o, underflow_o, early_fs_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_frame(2'd0, 8'h00, 1'b0, "R1 shifter cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule